// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface Detector

This block sits at the front of a peripheral's host port and decides, at run time, which of two bus protocols the host is speaking. After reset it treats its two active-low strobe pins as a separate read strobe and write strobe, as a generic local bus does. If both pins are ever seen asserted on the same synchronized sample, an input that has no legal meaning on the local bus, the block switches to a 68000-style protocol. In that protocol the former read pin carries the data strobe and the former write pin carries the read/not-write level. Only a hardware reset returns the block to local-bus mode.

Both strobe pins pass through a two-flop synchronizer. The block turns them into single-cycle internal read and write enables. Each enable is gated by a match of the upper address bits against a base address value, and it carries the low address bits as the register offset. When the protocol switches, a flag marks the new mode as unconfirmed. The first write that matches the address clears the flag. While the flag is set, read data toward the host is forced to zero. The latency from a pin edge to an enable is the same in both modes, so the first access in the new mode is no slower than a local-bus access.

Top module: `hbModeDetect`

## Requirements
- R1: After reset the block is in local-bus mode (`m68kMode` = 0), `unconfirmed` is 0, and neither `rdEn` nor `wrEn` is asserted.
- R2: In local-bus mode, a falling edge on `rdStrbN` while `wrStrbN` stays high, with an address hit, produces exactly one single-cycle `rdEn` pulse, and `accOffset` equals the low OFFS_W address bits.
- R3: In local-bus mode, a rising edge on `wrStrbN` while `rdStrbN` stays high, with an address hit, produces exactly one single-cycle `wrEn` pulse.
- R4: An address hit means that `addr[ADDR_W-1:OFFS_W]` equals `baseAddr`. On a miss, no enable is produced in either mode.
- R5: A synchronized sample on which both strobes are low sets `m68kMode` and `unconfirmed` on the next clock edge, whatever the address is. That sample produces no `rdEn` and no `wrEn`.
- R6: Once set, `m68kMode` stays set under any strobe activity. Only `rstN` low clears it.
- R7: In 68000 mode, a falling edge of the data strobe (`rdStrbN`) while R/nW (`wrStrbN`) is high produces one `rdEn` pulse on a hit.
- R8: In 68000 mode, a rising edge of the data strobe while R/nW was low on the previous sample produces one `wrEn` pulse on a hit. The write is taken when the strobe rises, not when it falls.
- R9: `unconfirmed` is cleared by the first address-hit write in 68000 mode, and a miss write leaves it set. While it is set, `rdDataOut` is zero. Otherwise `rdDataOut` equals `coreRdData`.
- R10: In both modes the enable goes high on the third rising clock edge after the pin change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low hardware reset, returns to local-bus mode |
| rdStrbN | input | 1 | Read strobe (local) or data strobe (68000), active low, asynchronous |
| wrStrbN | input | 1 | Write strobe (local) or R/nW level (68000), asynchronous |
| addr | input | ADDR_W | Host address, stable throughout an access |
| baseAddr | input | BASE_W | Base address register contents compared with the upper address bits |
| coreRdData | input | DATA_W | Read data from the peripheral core |
| rdEn | output | 1 | Single-cycle internal read enable |
| wrEn | output | 1 | Single-cycle internal write enable |
| accOffset | output | OFFS_W | Register offset captured with the last enable |
| rdDataOut | output | DATA_W | Read data toward the host, zero while unconfirmed |
| m68kMode | output | 1 | Sticky 68000-protocol flag |
| unconfirmed | output | 1 | Mode entered but no confirming write yet |

## Verification
The mode switch and a local-bus read edge can fall on the same synchronized sample, because the switch is triggered by a read strobe that falls while the write strobe is low. The bench provokes this by driving both pins low on the same clock edge. It judges the result by checking that no read enable appears while the mode and unconfirmed flags rise together. A second coincidence is a write pulse and the clearing of the unconfirmed flag on the same edge. This is tested both with a miss address, which must leave the flag set, and with a hit address, which must clear it in the same cycle that `wrEn` pulses.

// File: rtl/hbModePkg.sv
package hbModePkg;
  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic rdReq;   // read request, before address gating
    logic wrReq;   // write request, before address gating
    logic unconf;  // mode entered, confirming write still pending
  } hbStrobeT;
endpackage

// File: rtl/hbSync.sv
module hbSync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dinN,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= dinN;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  // active-high assertion level
  assign lvl = ~stg[STAGES-1];
endmodule

// File: rtl/hbCtrl.sv
module hbCtrl
  import hbModePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdLvl,    // read pin / data strobe asserted
  input  logic     wrLvl,    // write pin asserted / R/nW low
  input  logic     addrHit,
  output hbStrobeT strb,
  output logic     m68kMode
);
  logic rdPrev, wrPrev, unconfQ;
  logic enterM68k, rdReqC, wrReqC;

  always_comb begin
    enterM68k = !m68kMode && rdLvl && wrLvl;
    if (!m68kMode) begin
      rdReqC = rdLvl && !rdPrev && !wrLvl;
      wrReqC = !wrLvl && wrPrev && !rdLvl;
    end else begin
      rdReqC = rdLvl && !rdPrev && !wrLvl;   // DS falls, R/nW high
      wrReqC = !rdLvl && rdPrev && wrPrev;   // DS rises, R/nW was low
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev   <= 1'b0;
      wrPrev   <= 1'b0;
      m68kMode <= 1'b0;
      unconfQ  <= 1'b0;
    end else begin
      rdPrev <= rdLvl;
      wrPrev <= wrLvl;
      if (enterM68k) begin
        m68kMode <= 1'b1;
        unconfQ  <= 1'b1;
      end else if (m68kMode && wrReqC && addrHit) begin
        unconfQ  <= 1'b0;
      end
    end
  end

  assign strb.rdReq  = rdReqC;
  assign strb.wrReq  = wrReqC;
  assign strb.unconf = unconfQ;
endmodule

// File: rtl/hbDatapath.sv
module hbDatapath
  import hbModePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BASE_W = 12,
  parameter int DATA_W = 16,
  localparam int OFFS_W = ADDR_W - BASE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbStrobeT          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] coreRdData,
  output logic              addrHit,
  output logic              rdEn,
  output logic              wrEn,
  output logic [OFFS_W-1:0] accOffset,
  output logic [DATA_W-1:0] rdDataOut
);
  assign addrHit = (addr[ADDR_W-1:OFFS_W] == baseAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEn      <= 1'b0;
      wrEn      <= 1'b0;
      accOffset <= '0;
    end else begin
      rdEn <= strb.rdReq && addrHit;
      wrEn <= strb.wrReq && addrHit;
      if ((strb.rdReq || strb.wrReq) && addrHit)
        accOffset <= addr[OFFS_W-1:0];
    end
  end

  assign rdDataOut = strb.unconf ? '0 : coreRdData;
endmodule

// File: rtl/hbModeDetect.sv
module hbModeDetect
  import hbModePkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BASE_W      = 12,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int OFFS_W     = ADDR_W - BASE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrbN,
  input  logic              wrStrbN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] coreRdData,
  output logic              rdEn,
  output logic              wrEn,
  output logic [OFFS_W-1:0] accOffset,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              m68kMode,
  output logic              unconfirmed
);
  logic [1:0] pinLvl;
  logic       addrHit;
  hbStrobeT   strb;

  hbSync #(.W(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .dinN({wrStrbN, rdStrbN}), .lvl(pinLvl)
  );

  hbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rdLvl(pinLvl[0]), .wrLvl(pinLvl[1]),
    .addrHit(addrHit), .strb(strb), .m68kMode(m68kMode)
  );

  hbDatapath #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .baseAddr(baseAddr),
    .coreRdData(coreRdData), .addrHit(addrHit), .rdEn(rdEn), .wrEn(wrEn),
    .accOffset(accOffset), .rdDataOut(rdDataOut)
  );

  assign unconfirmed = strb.unconf;
endmodule

// File: rtl/hbModeDetectChk.sv
module hbModeDetectChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic              m68kMode,
  input logic              unconfirmed,
  input logic [DATA_W-1:0] rdDataOut
);
  p_no_dual_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));
  p_rd_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
  p_entry_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m68kMode) |-> (unconfirmed && !rdEn && !wrEn));
  p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    m68kMode |=> m68kMode);
  p_unconf_in_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    unconfirmed |-> m68kMode);
  p_unconf_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    unconfirmed |-> (rdDataOut == '0));
  p_confirm_by_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unconfirmed) |-> wrEn);
endmodule

bind hbModeDetect hbModeDetectChk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .m68kMode(m68kMode),
  .unconfirmed(unconfirmed), .rdDataOut(rdDataOut)
);

// File: tb/sim_hbModeDetect.sv
module sim_hbModeDetect;
  localparam int ADDR_W = 16;
  localparam int BASE_W = 12;
  localparam int DATA_W = 16;
  localparam int OFFS_W = ADDR_W - BASE_W;
  localparam logic [BASE_W-1:0] BASE = 12'h3A1;
  localparam logic [DATA_W-1:0] CORE = 16'hA5C3;

  // vector: {isWrite, expectPulse, address}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 16'h3A15},
    {1'b1, 1'b1, 16'h3A1C},
    {1'b0, 1'b0, 16'h3A25},
    {1'b1, 1'b0, 16'h0A13},
    {1'b0, 1'b1, 16'h3A10},
    {1'b1, 1'b1, 16'h3A1F}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrbN = 1'b1, wrStrbN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] coreRdData = CORE;
  logic rdEn, wrEn, m68kMode, unconfirmed;
  logic [OFFS_W-1:0] accOffset;
  logic [DATA_W-1:0] rdDataOut;

  int nTests = 0, nFail = 0;
  int rdCnt = 0, wrCnt = 0;
  logic [OFFS_W-1:0] lastOff = '0;

  always #4 clk = ~clk;

  hbModeDetect u0 (
    .clk(clk), .rstN(rstN), .rdStrbN(rdStrbN), .wrStrbN(wrStrbN),
    .addr(addr), .baseAddr(BASE), .coreRdData(coreRdData),
    .rdEn(rdEn), .wrEn(wrEn), .accOffset(accOffset), .rdDataOut(rdDataOut),
    .m68kMode(m68kMode), .unconfirmed(unconfirmed)
  );

  always @(negedge clk) begin
    if (rdEn) begin rdCnt++; lastOff = accOffset; end
    if (wrEn) begin wrCnt++; lastOff = accOffset; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic localAcc(input logic isWr, input logic [ADDR_W-1:0] a);
    addr = a;
    cyc(1);
    if (isWr) wrStrbN = 1'b0; else rdStrbN = 1'b0;
    cyc(5);
    wrStrbN = 1'b1; rdStrbN = 1'b1;
    cyc(6);
  endtask

  task automatic m68kAcc(input logic isWr, input logic [ADDR_W-1:0] a);
    addr = a;
    wrStrbN = !isWr;
    cyc(2);
    rdStrbN = 1'b0;
    cyc(5);
    rdStrbN = 1'b1;
    cyc(6);
    wrStrbN = 1'b1;
    cyc(3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    int r0, w0;
    cyc(3);
    // R1 reset state
    chk("R1 mode", m68kMode, 0);
    chk("R1 unconfirmed", unconfirmed, 0);
    chk("R1 enables", {rdEn, wrEn}, 0);
    rstN = 1'b1;
    cyc(3);

    // table of local-bus accesses: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      r0 = rdCnt; w0 = wrCnt;
      localAcc(VEC[i][17], VEC[i][15:0]);
      if (VEC[i][17]) begin
        chk("R3 write pulses", wrCnt - w0, VEC[i][16] ? 1 : 0);
        chk("R4 no read on write", rdCnt - r0, 0);
      end else begin
        chk("R2 read pulses", rdCnt - r0, VEC[i][16] ? 1 : 0);
        chk("R4 no write on read", wrCnt - w0, 0);
      end
      if (VEC[i][16]) chk("R2 offset", lastOff, VEC[i][3:0]);
    end
    chk("R1 still local", m68kMode, 0);

    // R10 local latency: enable on third rising edge
    addr = 16'h3A16;
    cyc(1);
    rdStrbN = 1'b0;
    cyc(2);
    chk("R10 local early", rdEn, 0);
    cyc(1);
    chk("R10 local on time", rdEn, 1);
    cyc(3);
    rdStrbN = 1'b1;
    cyc(5);

    // R5 simultaneous assertion at a miss address
    r0 = rdCnt; w0 = wrCnt;
    addr = 16'h7770;
    cyc(1);
    rdStrbN = 1'b0; wrStrbN = 1'b0;
    cyc(2);
    chk("R5 mode not yet", m68kMode, 0);
    cyc(1);
    chk("R5 mode entered", m68kMode, 1);
    chk("R5 unconfirmed set", unconfirmed, 1);
    chk("R9 data zero", rdDataOut, 0);
    rdStrbN = 1'b1; wrStrbN = 1'b1;
    cyc(6);
    chk("R5 no enables", (rdCnt - r0) + (wrCnt - w0), 0);
    chk("R9 miss write keeps flag", unconfirmed, 1);

    // R7 read before confirmation
    r0 = rdCnt;
    m68kAcc(1'b0, 16'h3A12);
    chk("R7 m68k read pulse", rdCnt - r0, 1);
    chk("R9 still unconfirmed", unconfirmed, 1);
    chk("R9 read data zero", rdDataOut, 0);

    // R8 write: enable only after DS rises, and R9 confirmation
    w0 = wrCnt;
    addr = 16'h3A1B;
    wrStrbN = 1'b0;
    cyc(2);
    rdStrbN = 1'b0;
    cyc(5);
    chk("R8 no write while DS low", wrCnt - w0, 0);
    rdStrbN = 1'b1;
    cyc(2);
    chk("R10 m68k early", wrEn, 0);
    cyc(1);
    chk("R10 m68k on time", wrEn, 1);
    chk("R9 cleared with write", unconfirmed, 0);
    cyc(4);
    wrStrbN = 1'b1;
    cyc(3);
    chk("R8 write pulses", wrCnt - w0, 1);
    chk("R8 offset", lastOff, 4'hB);
    chk("R9 data passes", rdDataOut, CORE);

    // R6 stickiness under local-looking patterns
    localAcc(1'b0, 16'h3A11);
    localAcc(1'b1, 16'h3A11);
    chk("R6 mode kept", m68kMode, 1);
    chk("R9 stays confirmed", unconfirmed, 0);

    // R6/R1 reset returns to local mode
    rstN = 1'b0;
    cyc(2);
    chk("R6 reset clears mode", m68kMode, 0);
    chk("R1 reset unconfirmed", unconfirmed, 0);
    rstN = 1'b1;
    cyc(3);
    r0 = rdCnt;
    localAcc(1'b0, 16'h3A13);
    chk("R2 local after reset", rdCnt - r0, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule